// File: doc/BRIEF.md
# Resynchronising Asynchronous Frame Receiver

This block listens permanently on a one-way serial line and captures fixed-length frames. The line idles high. A frame opens with a low start bit, continues with a fixed number of payload bits sent least significant bit first, and closes with one high stop bit. The receiver has no transmit path. It confirms the start bit at its midpoint. It samples every later bit in the middle of its period and shifts the bits into a word. When the stop bit is good, it presents that word on a parallel output together with a one-cycle valid strobe.

Sender and receiver clocks are never exactly equal. To stop the resulting drift from building up over a long frame, the bit-timing counter restarts on every transition of the received data, rising or falling. Each data edge therefore re-aligns the sampling point to the true bit boundary.

The serial input passes through a two-flop synchroniser before any edge is detected. A bad stop bit raises a one-cycle framing-error pulse, and that frame's payload is discarded. With the defaults (54 payload bits, 48 clocks per bit), one bit lasts 480 ns at a 100 MHz system clock.

Top module: `rxf_frame_rx`

## Requirements
- R1: While reset is held and after it is released, `data_o` is all zeros and `valid_o` and `ferr_o` are low until a frame completes.
- R2: A line held at 1 with no falling edge produces no `valid_o` and no `ferr_o` pulse.
- R3: A low pulse shorter than or equal to half a bit period (24 cycles by default) is rejected as a false start: no strobe and no error are produced, and the next proper frame is received intact.
- R4: The DATA_W payload bits (default 54) that follow the start bit are assembled least significant bit first, so the first payload bit on the line appears at `data_o[0]`.
- R5: Each frame whose stop bit is 1 gives exactly one single-cycle `valid_o` pulse. `data_o` changes only in that cycle and holds its value until the next good frame.
- R6: Frames whose bit period differs from nominal by up to ±3 cycles (45 to 51 cycles) are received correctly when every bit differs from the one before it, because each data edge restarts the bit counter.
- R7: At the nominal bit period, long runs of identical bits (an all-zeros or all-ones payload) are received correctly, because the counter wraps every CLKS_PER_BIT cycles between edges.
- R8: A 0 sampled in the stop-bit position gives a single-cycle `ferr_o` pulse, gives no `valid_o`, and leaves `data_o` unchanged.
- R9: Two frames sent back to back, with only the single stop bit between them, are both received, in order.
- R10: `valid_o` and `ferr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | DATA_W | Payload of the last good frame |
| valid_o | output | 1 | One-cycle strobe when a new payload is presented |
| ferr_o | output | 1 | One-cycle pulse on a bad stop bit |

## Verification
The restart of the bit counter and the midpoint sample can fall due in the same cycle. This happens when a data edge arrives exactly half a bit after the previous one. In that cycle the restart wins and the sample is skipped. The bench provokes this with a low pulse of exactly half a bit on an idle line. The collision is judged correct if no strobe and no error appear and a proper frame sent afterwards arrives unharmed. Drifted senders at 45 and 51 cycles per bit exercise the same restart path across a whole frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rxf_state_e;
endpackage

// File: rtl/rxf_sync.sv
// Two-flop synchroniser followed by a transition detector.
module rxf_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic line_o,
  output logic edge_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign line_o = sync_q;
  assign edge_o = sync_q ^ prev_q;
  assign fall_o = prev_q & ~sync_q;
endmodule

// File: rtl/rxf_bit_timer.sv
// Bit-period counter that restarts on every data edge and marks the bit midpoint.
module rxf_bit_timer #(
  parameter int CLKS_PER_BIT = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic mid_o
);
  localparam int CW   = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam logic [CW-1:0] LAST    = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] MID_CNT = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart_i || cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // A restart in the same cycle takes priority over the sample.
  assign mid_o = (cnt_q == MID_CNT) && !restart_i;
endmodule

// File: rtl/rxf_ctrl.sv
// Frame sequencing, payload shifting and registered outputs.
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int DATA_W = 54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_i,
  input  logic              fall_i,
  input  logic              mid_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

  rxf_state_e        state_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shift_q <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fall_i) state_q <= ST_START;
        end
        ST_START: begin
          if (mid_i) begin
            if (!line_i) begin
              state_q <= ST_DATA;
              idx_q   <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_DATA: begin
          if (mid_i) begin
            shift_q <= {line_i, shift_q[DATA_W-1:1]};
            if (idx_q == LAST_IDX) begin
              state_q <= ST_STOP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (mid_i) begin
            state_q <= ST_IDLE;
            if (line_i) begin
              data_o  <= shift_q;
              valid_o <= 1'b1;
            end else begin
              ferr_o <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxf_frame_rx.sv
// Top: resynchronising fixed-length frame receiver.
module rxf_frame_rx #(
  parameter int DATA_W       = 54,
  parameter int CLKS_PER_BIT = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o
);
  logic line_s, edge_s, fall_s, mid_s;

  rxf_sync u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (rx_line_i),
    .line_o  (line_s),
    .edge_o  (edge_s),
    .fall_o  (fall_s)
  );

  rxf_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart_i (edge_s),
    .mid_o     (mid_s)
  );

  rxf_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .line_i  (line_s),
    .fall_i  (fall_s),
    .mid_i   (mid_s),
    .data_o  (data_o),
    .valid_o (valid_o),
    .ferr_o  (ferr_o)
  );
endmodule

// File: rtl/rxf_frame_rx_chk.sv
module rxf_frame_rx_chk #(
  parameter int DATA_W = 54
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              ferr_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (data_o == '0 && !valid_o && !ferr_o));

  // R10
  excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && ferr_o));

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |=> (valid_o || $stable(data_o)));

  // R8
  ferr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ferr_o |=> !ferr_o);

  // R8
  ferr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ferr_o |=> $stable(data_o));
endmodule

bind rxf_frame_rx rxf_frame_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .data_o  (data_o),
  .valid_o (valid_o),
  .ferr_o  (ferr_o)
);

// File: tb/rxf_frame_rx_bench.sv
module rxf_frame_rx_bench;
  localparam int DW  = 54;
  localparam int CPB = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          line = 1'b1;
  logic [DW-1:0] data_o;
  logic          valid_o, ferr_o;

  int n_tests = 0;
  int n_fail  = 0;
  int vcnt = 0;
  int ecnt = 0;
  logic [DW-1:0] last_w = '0;
  logic [DW-1:0] prev_w = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rxf_frame_rx #(.DATA_W(DW), .CLKS_PER_BIT(CPB)) u_rxf_frame_rx (
    .clk(clk), .rst(rst), .rx_line_i(line),
    .data_o(data_o), .valid_o(valid_o), .ferr_o(ferr_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o) begin
        vcnt   = vcnt + 1;
        prev_w = last_w;
        last_w = data_o;
      end
      if (ferr_o) ecnt = ecnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    line = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int per);
    line = b;
    repeat (per) @(negedge clk);
  endtask

  task automatic send_frame(input logic [DW-1:0] w, input int per, input logic stop_v);
    send_bit(1'b0, per);
    for (int i = 0; i < DW; i++) send_bit(w[i], per);
    send_bit(stop_v, per);
    line = 1'b1;
  endtask

  task automatic t_reset;
    chk(data_o == '0 && !valid_o && !ferr_o, "R1 reset outputs", {data_o[DW-1:0]}, 0);
  endtask

  task automatic t_idle;
    int v0 = vcnt, e0 = ecnt;
    idle(4 * CPB);
    chk(vcnt == v0 && ecnt == e0, "R2 idle line silent", vcnt - v0 + ecnt - e0, 0);
  endtask

  task automatic t_good(input logic [DW-1:0] w, input int per, input string tag);
    int v0 = vcnt, e0 = ecnt;
    send_frame(w, per, 1'b1);
    idle(2 * CPB);
    chk(vcnt == v0 + 1, {tag, " strobe count"}, vcnt - v0, 1);
    chk(ecnt == e0, {tag, " no error"}, ecnt - e0, 0);
    chk(last_w == w, {tag, " payload"}, last_w, w);
  endtask

  task automatic t_glitch(input int len);
    int v0 = vcnt, e0 = ecnt;
    line = 1'b0;
    repeat (len) @(negedge clk);
    idle(3 * CPB);
    // R3: false start rejected
    chk(vcnt == v0 && ecnt == e0, "R3 glitch ignored", vcnt - v0 + ecnt - e0, 0);
    chk(data_o == last_w, "R3 data unchanged", data_o, last_w);
  endtask

  task automatic t_bad_stop;
    int v0 = vcnt, e0 = ecnt;
    logic [DW-1:0] keep = data_o;
    send_frame(54'h0F0F_1234_5678_9A, CPB, 1'b0);
    idle(2 * CPB);
    chk(ecnt == e0 + 1, "R8 error pulse", ecnt - e0, 1);
    chk(vcnt == v0, "R8 no strobe", vcnt - v0, 0);
    chk(data_o == keep, "R8 data kept", data_o, keep);
  endtask

  task automatic t_b2b;
    int v0 = vcnt;
    logic [DW-1:0] a = 54'h2A_5A5A_C3C3_0F0F;
    logic [DW-1:0] b = 54'h01_2345_6789_ABCD;
    send_frame(a, CPB, 1'b1);
    send_frame(b, CPB, 1'b1);
    idle(2 * CPB);
    chk(vcnt == v0 + 2, "R9 two strobes", vcnt - v0, 2);
    chk(prev_w == a, "R9 first frame", prev_w, a);
    chk(last_w == b, "R9 second frame", last_w, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    t_good(54'h12_3456_789A_BCDE, CPB, "R4 LSB-first");
    t_good(54'h00_0000_0000_0001, CPB, "R4 bit0");
    t_glitch(CPB / 2);
    t_glitch(10);
    t_good(54'h20_0000_0000_0000, CPB, "R3 frame after glitch");
    t_good(54'h00_0000_0000_0000, CPB, "R7 all zeros");
    t_good(54'h3F_FFFF_FFFF_FFFF, CPB, "R7 all ones");
    t_good(54'h15_5555_5555_5555, CPB - 3, "R6 fast sender");
    t_good(54'h15_5555_5555_5555, CPB + 3, "R6 slow sender");
    t_good(54'h2A_AAAA_AAAA_AAAA, CPB + 3, "R6 slow sender alt");
    t_bad_stop();
    t_b2b();
    t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule